// File: doc/BRIEF.md
# Indexed DMA Channel Sequencer

This block is the address and count engine of a single DMA channel. A start strobe loads the source and destination base addresses and the element and frame counts. While the channel is active it raises a transfer request. Each acknowledge from the bus side completes one 16-bit beat and moves both addresses on.

Inside a frame, each side adds an element step. After the last element of a frame it adds a frame step instead. Each side picks its steps from one of two register pairs through its own select bit.

Doubleword elements travel as two 16-bit beats. A word-half output marks the second beat. Two operating modes exist: multiframe, which runs a fixed number of frames and then stops, and autobuffer, which cycles over one circular buffer. A two-bit interrupt setting chooses when the CPU interrupt pulse fires.

Top module: `dma_seq_top`

## Requirements
- R1: After reset `reqO`, `doneO`, `irqO` and `hiHalfO` are 0 and both addresses are 0. A cycle with `startI`=1 and `enableI`=1 loads `srcAddrO`/`dstAddrO` from the base inputs and sets `reqO` to 1 from the next cycle on.
- R2: When an acknowledged beat is not the final beat of a frame, each address adds its element step. `srcSelI`/`dstSelI`=0 picks `elemIdx0I`, and 1 picks `elemIdx1I`. The new address is visible one cycle after the acknowledge.
- R3: In multiframe mode (`abuModeI`=0), the final beat of every frame adds the frame step instead, including when there is only one frame. Select 0 picks `frameIdx0I`, and select 1 picks `frameIdx1I`.
- R4: With `dblWordI`=1, an element takes two acknowledged beats. `hiHalfO` is 1 between the first and second beat. The first beat always adds the element step, and the element counter advances only on the second beat.
- R5: In multiframe mode, a frame count of N runs N frames of E elements. After the final beat, `doneO` pulses for one cycle and `reqO` drops in that same cycle.
- R6: An element count of 0 behaves as 1, and a frame count of 0 behaves as 1.
- R7: With `intEnI`=0, `irqO` stays 0 in every mode.
- R8: In multiframe mode with `intModeI`=0, `irqO` pulses only together with `doneO`. With `intModeI`=1, it also pulses one cycle after the final beat of every frame.
- R9: In autobuffer mode (`abuModeI`=1), `irqO` pulses when the buffer of E elements is full. With `intModeI`=1, it also pulses after element floor(E/2) completes, provided floor(E/2) > 0. The frame count is not used in this mode.
- R10: In autobuffer mode, completing element E reloads both addresses from the base inputs. The channel keeps requesting until `enableI` goes to 0, and `doneO` never pulses.
- R11: `ackI` while `reqO`=0 changes nothing. `enableI`=0 clears `reqO` on the next cycle.
- R12: Address steps are 16-bit two's-complement values added modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| startI | input | 1 | load configuration and activate (needs enableI) |
| enableI | input | 1 | channel enable; 0 stops the channel |
| ackI | input | 1 | one 16-bit beat done |
| srcBaseI | input | AW | source start address |
| dstBaseI | input | AW | destination start address |
| elemCntI | input | ECW | elements per frame (buffer length in autobuffer) |
| frameCntI | input | FCW | frames per block |
| elemIdx0I | input | AW | element step, pair 0 |
| elemIdx1I | input | AW | element step, pair 1 |
| frameIdx0I | input | AW | frame step, pair 0 |
| frameIdx1I | input | AW | frame step, pair 1 |
| srcSelI | input | 1 | step pair used by source |
| dstSelI | input | 1 | step pair used by destination |
| dblWordI | input | 1 | 32-bit elements as two beats |
| abuModeI | input | 1 | 1 = autobuffer, 0 = multiframe |
| intEnI | input | 1 | interrupt enable |
| intModeI | input | 1 | interrupt timing select |
| srcAddrO | output | AW | current source address |
| dstAddrO | output | AW | current destination address |
| reqO | output | 1 | transfer request (channel active) |
| hiHalfO | output | 1 | next beat is the second half of a doubleword |
| doneO | output | 1 | one-cycle end-of-block pulse |
| irqO | output | 1 | one-cycle CPU interrupt pulse |

## Verification
Every result of an acknowledge appears exactly one cycle later: the new addresses, `hiHalfO`, and the `doneO`/`irqO` pulses. `reqO` rises one cycle after start and falls one cycle after the final beat or after enable is removed. The bench drives inputs on the falling edge and advances a behavioural model on each rising edge. It then compares every output one time unit after that edge, so each result is checked in the cycle it is due and not a cycle early or late.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  // strobes from control to address datapath
  typedef struct packed {
    logic load;       // copy bases into address registers
    logic stepElem;   // add selected element step
    logic stepFrame;  // add selected frame step
    logic wrap;       // circular buffer return to bases
  } dpCmd_t;
endpackage

// File: rtl/dma_seq_dp.sv
module dma_seq_dp
  import dma_seq_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCmd_t        cmdI,
  input  logic [AW-1:0] srcBaseI,
  input  logic [AW-1:0] dstBaseI,
  input  logic [AW-1:0] elemIdx0I,
  input  logic [AW-1:0] elemIdx1I,
  input  logic [AW-1:0] frameIdx0I,
  input  logic [AW-1:0] frameIdx1I,
  input  logic          srcSelI,
  input  logic          dstSelI,
  output logic [AW-1:0] srcAddrO,
  output logic [AW-1:0] dstAddrO
);
  localparam int SIDES = 2;

  logic [AW-1:0] baseArr [SIDES];
  logic [AW-1:0] addrArr [SIDES];
  logic          selArr  [SIDES];

  assign baseArr[0] = srcBaseI;
  assign baseArr[1] = dstBaseI;
  assign selArr[0]  = srcSelI;
  assign selArr[1]  = dstSelI;

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    logic [AW-1:0] eStep, fStep;
    assign eStep = selArr[s] ? elemIdx1I  : elemIdx0I;
    assign fStep = selArr[s] ? frameIdx1I : frameIdx0I;
    always_ff @(posedge clk) begin
      if (!rstN)                          addrArr[s] <= '0;
      else if (cmdI.load || cmdI.wrap)    addrArr[s] <= baseArr[s];
      else if (cmdI.stepFrame)            addrArr[s] <= addrArr[s] + fStep;
      else if (cmdI.stepElem)             addrArr[s] <= addrArr[s] + eStep;
    end
  end

  assign srcAddrO = addrArr[0];
  assign dstAddrO = addrArr[1];

  // R11
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdI.load || cmdI.wrap || cmdI.stepFrame || cmdI.stepElem)
      |=> ($stable(srcAddrO) && $stable(dstAddrO)));
endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
#(
  parameter int ECW = 16,
  parameter int FCW = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           startI,
  input  logic           enableI,
  input  logic           ackI,
  input  logic [ECW-1:0] elemCntI,
  input  logic [FCW-1:0] frameCntI,
  input  logic           dblWordI,
  input  logic           abuModeI,
  input  logic           intEnI,
  input  logic           intModeI,
  output dpCmd_t         cmdO,
  output logic           reqO,
  output logic           hiHalfO,
  output logic           doneO,
  output logic           irqO
);
  localparam logic [ECW-1:0] ONE_E = ECW'(1);
  localparam logic [FCW-1:0] ONE_F = FCW'(1);

  logic           active, beat, doneQ, irqQ;
  logic [ECW-1:0] pos, elemLast, halfPt;
  logic [FCW-1:0] framesLeft;

  logic [ECW-1:0] effCnt, posNext;
  logic           beatAck, firstHalf, elemEnd, isLast, blockEnd, irqNext;

  assign effCnt    = (elemCntI == '0) ? ONE_E : elemCntI;
  assign posNext   = pos + ONE_E;
  assign beatAck   = active && ackI && enableI && !startI;
  assign firstHalf = beatAck && dblWordI && !beat;
  assign elemEnd   = beatAck && !firstHalf;
  assign isLast    = (pos == elemLast);
  assign blockEnd  = elemEnd && isLast && !abuModeI && (framesLeft == ONE_F);

  always_comb begin
    cmdO.load      = enableI && startI;
    cmdO.stepElem  = firstHalf || (elemEnd && !isLast);
    cmdO.stepFrame = elemEnd && isLast && !abuModeI;
    cmdO.wrap      = elemEnd && isLast && abuModeI;
  end

  always_comb begin
    irqNext = 1'b0;
    if (elemEnd && isLast)
      irqNext = abuModeI || (framesLeft == ONE_F) || intModeI;
    else if (elemEnd && abuModeI && intModeI && halfPt != '0 && posNext == halfPt)
      irqNext = 1'b1;
    irqNext = irqNext && intEnI;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0; beat <= 1'b0; doneQ <= 1'b0; irqQ <= 1'b0;
      pos <= '0; elemLast <= '0; halfPt <= '0; framesLeft <= '0;
    end else begin
      doneQ <= blockEnd;
      irqQ  <= irqNext;
      if (!enableI) begin
        active <= 1'b0;
      end else if (startI) begin
        active     <= 1'b1;
        beat       <= 1'b0;
        pos        <= '0;
        elemLast   <= effCnt - ONE_E;
        halfPt     <= effCnt >> 1;
        framesLeft <= (frameCntI == '0) ? ONE_F : frameCntI;
      end else if (firstHalf) begin
        beat <= 1'b1;
      end else if (elemEnd) begin
        beat <= 1'b0;
        if (!isLast) pos <= posNext;
        else begin
          pos <= '0;
          if (!abuModeI) begin
            if (framesLeft == ONE_F) active <= 1'b0;
            else framesLeft <= framesLeft - ONE_F;
          end
        end
      end
    end
  end

  assign reqO    = active;
  assign hiHalfO = beat;
  assign doneO   = doneQ;
  assign irqO    = irqQ;

  // R5
  no_req_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneO |-> !reqO);
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneO |=> !doneO);
  // R7
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    !intEnI |=> !irqO);
  // R4
  hi_half_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hiHalfO) |-> $past(dblWordI && ackI));
endmodule

// File: rtl/dma_seq_top.sv
module dma_seq_top
  import dma_seq_pkg::*;
#(
  parameter int AW  = 16,
  parameter int ECW = 16,
  parameter int FCW = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           startI,
  input  logic           enableI,
  input  logic           ackI,
  input  logic [AW-1:0]  srcBaseI,
  input  logic [AW-1:0]  dstBaseI,
  input  logic [ECW-1:0] elemCntI,
  input  logic [FCW-1:0] frameCntI,
  input  logic [AW-1:0]  elemIdx0I,
  input  logic [AW-1:0]  elemIdx1I,
  input  logic [AW-1:0]  frameIdx0I,
  input  logic [AW-1:0]  frameIdx1I,
  input  logic           srcSelI,
  input  logic           dstSelI,
  input  logic           dblWordI,
  input  logic           abuModeI,
  input  logic           intEnI,
  input  logic           intModeI,
  output logic [AW-1:0]  srcAddrO,
  output logic [AW-1:0]  dstAddrO,
  output logic           reqO,
  output logic           hiHalfO,
  output logic           doneO,
  output logic           irqO
);
  dpCmd_t cmd;

  dma_seq_ctrl #(.ECW(ECW), .FCW(FCW)) u_ctrl (
    .clk(clk), .rstN(rstN), .startI(startI), .enableI(enableI), .ackI(ackI),
    .elemCntI(elemCntI), .frameCntI(frameCntI), .dblWordI(dblWordI),
    .abuModeI(abuModeI), .intEnI(intEnI), .intModeI(intModeI),
    .cmdO(cmd), .reqO(reqO), .hiHalfO(hiHalfO), .doneO(doneO), .irqO(irqO)
  );

  dma_seq_dp #(.AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .cmdI(cmd), .srcBaseI(srcBaseI), .dstBaseI(dstBaseI),
    .elemIdx0I(elemIdx0I), .elemIdx1I(elemIdx1I),
    .frameIdx0I(frameIdx0I), .frameIdx1I(frameIdx1I),
    .srcSelI(srcSelI), .dstSelI(dstSelI),
    .srcAddrO(srcAddrO), .dstAddrO(dstAddrO)
  );
endmodule

// File: tb/dma_seq_top_bench.sv
module dma_seq_top_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startI = 0, enableI = 0, ackI = 0;
  logic [15:0] srcBaseI = 0, dstBaseI = 0, elemCntI = 0;
  logic [7:0]  frameCntI = 0;
  logic [15:0] elemIdx0I = 0, elemIdx1I = 0, frameIdx0I = 0, frameIdx1I = 0;
  logic srcSelI = 0, dstSelI = 0, dblWordI = 0, abuModeI = 0, intEnI = 0, intModeI = 0;
  logic [15:0] srcAddrO, dstAddrO;
  logic reqO, hiHalfO, doneO, irqO;

  int checks = 0, failures = 0;
  string curReq = "R1";
  int doneSeen = 0, irqSeen = 0;

  dma_seq_top u_dma_seq_top (.*);

  always #(CLK_P/2) clk = ~clk;

  // behavioural reference
  logic [15:0] mSrc, mDst;
  int mPos, mLen, mFrames;
  bit mActive, mBeat, mDone, mIrq;

  function automatic logic [15:0] eStep(bit s);
    return s ? elemIdx1I : elemIdx0I;
  endfunction
  function automatic logic [15:0] fStep(bit s);
    return s ? frameIdx1I : frameIdx0I;
  endfunction

  task automatic cmp(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", curReq, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mSrc = 0; mDst = 0; mPos = 0; mLen = 1; mFrames = 0;
      mActive = 0; mBeat = 0; mDone = 0; mIrq = 0;
    end else begin
      mDone = 0; mIrq = 0;
      if (!enableI) mActive = 0;
      else if (startI) begin
        mActive = 1; mBeat = 0; mPos = 0;
        mSrc = srcBaseI; mDst = dstBaseI;
        mLen = (elemCntI == 0) ? 1 : int'(elemCntI);
        mFrames = (frameCntI == 0) ? 1 : int'(frameCntI);
      end else if (mActive && ackI) begin
        if (dblWordI && !mBeat) begin
          mBeat = 1; mSrc += eStep(srcSelI); mDst += eStep(dstSelI);
        end else begin
          mBeat = 0;
          if (mPos == mLen - 1) begin
            mPos = 0;
            if (abuModeI) begin
              mSrc = srcBaseI; mDst = dstBaseI; mIrq = intEnI;
            end else begin
              mSrc += fStep(srcSelI); mDst += fStep(dstSelI);
              if (mFrames == 1) begin mActive = 0; mDone = 1; mIrq = intEnI; end
              else begin mFrames--; mIrq = intEnI && intModeI; end
            end
          end else begin
            mSrc += eStep(srcSelI); mDst += eStep(dstSelI); mPos++;
            if (abuModeI && intEnI && intModeI && (mLen/2) > 0 && mPos == mLen/2) mIrq = 1;
          end
        end
      end
    end
    #1;
    cmp("srcAddrO", srcAddrO, mSrc);
    cmp("dstAddrO", dstAddrO, mDst);
    cmp("reqO", reqO, mActive);
    cmp("hiHalfO", hiHalfO, mBeat);
    cmp("doneO", doneO, mDone);
    cmp("irqO", irqO, mIrq);
    if (doneO) doneSeen++;
    if (irqO) irqSeen++;
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic startCh(input logic [15:0] sb, db, ec, input logic [7:0] fc);
    @(negedge clk);
    srcBaseI = sb; dstBaseI = db; elemCntI = ec; frameCntI = fc;
    enableI = 1; startI = 1; ackI = 0;
    @(negedge clk);
    startI = 0;
  endtask

  task automatic acks(int n, bit gaps);
    for (int i = 0; i < n; i++) begin
      ackI = 1; tick();
      if (gaps) begin ackI = 0; tick(); end
    end
    ackI = 0;
  endtask

  initial begin
    #(CLK_P * 100000);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    elemIdx0I = 16'd2; elemIdx1I = 16'hFFFF;
    frameIdx0I = 16'd10; frameIdx1I = 16'hFFFB;
    tick(3);
    curReq = "R1";
    rstN = 1; tick(2);
    // R11: ack while idle ignored
    curReq = "R11"; ackI = 1; tick(3); ackI = 0;
    // R2 R3 R5 R8: multiframe, sel 0 / 1, irq mode 0
    curReq = "R2"; srcSelI = 0; dstSelI = 1; intEnI = 1; intModeI = 0;
    startCh(16'h0100, 16'h0200, 16'd3, 8'd2);
    acks(2, 0);
    curReq = "R3"; acks(1, 0);
    curReq = "R5"; acks(3, 0); tick(3);
    // R8 mode 1 with gaps, swapped selects
    curReq = "R8"; srcSelI = 1; dstSelI = 0; intModeI = 1; doneSeen = 0; irqSeen = 0;
    startCh(16'h0400, 16'h0500, 16'd2, 8'd3);
    acks(6, 1); tick(2);
    cmp("R8 irq count", irqSeen, 3);
    cmp("R5 done count", doneSeen, 1);
    // R4 doubleword
    curReq = "R4"; dblWordI = 1; intModeI = 0;
    startCh(16'h1000, 16'h2000, 16'd2, 8'd1);
    acks(4, 1); tick(2);
    dblWordI = 0;
    // R6 zero counts
    curReq = "R6"; doneSeen = 0;
    startCh(16'h3000, 16'h3100, 16'd0, 8'd0);
    acks(1, 0); tick(2);
    cmp("R6 done count", doneSeen, 1);
    // R7 interrupts disabled
    curReq = "R7"; intEnI = 0; intModeI = 1; irqSeen = 0;
    startCh(16'h0040, 16'h0050, 16'd2, 8'd2);
    acks(4, 0); tick(2);
    cmp("R7 irq count", irqSeen, 0);
    // R9 autobuffer mode 0, then mode 1 with odd length
    curReq = "R9"; intEnI = 1; intModeI = 0; abuModeI = 1; irqSeen = 0;
    startCh(16'h0800, 16'h0900, 16'd4, 8'd7);
    acks(8, 0); tick(2);
    cmp("R9 full-only irq count", irqSeen, 2);
    intModeI = 1; irqSeen = 0;
    startCh(16'h0800, 16'h0900, 16'd5, 8'd1);
    acks(5, 1); tick(2);
    cmp("R9 half+full irq count", irqSeen, 2);
    // R10 wrap and continue, then disable
    curReq = "R10"; doneSeen = 0;
    acks(7, 0);
    cmp("R10 still requesting", reqO, 1);
    cmp("R10 no done", doneSeen, 0);
    enableI = 0; tick(1);
    curReq = "R11"; ackI = 1; tick(3); ackI = 0; enableI = 1; tick(1);
    // R12 modular wrap with negative steps
    curReq = "R12"; abuModeI = 0; elemIdx0I = 16'd3; frameIdx0I = 16'h8000;
    srcSelI = 0; dstSelI = 1;
    startCh(16'hFFFE, 16'h0001, 16'd3, 8'd2);
    acks(6, 0); tick(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule